// File: doc/BRIEF.md
# Interrupt Status and Enable Unit

This block gathers the eight event sources of a serial bus controller into one level interrupt line. Each source signals an event with a one-cycle pulse. The pulse latches a bit in a pending-event register, and the bit stays set until software clears it. A per-source mask and a single master switch decide which latched events reach the interrupt output. The output is registered, so it follows the register state one clock later.

Software reaches the unit through a 32-bit word port with byte addresses. Four words are mapped: the master switch, the latched events, the per-source mask, and a reset trigger. The latched events are cleared by writing ones to the bits to be cleared. Writing the key value to the reset trigger returns the unit to its reset state and sends a one-cycle reset pulse to the rest of the controller.

Top module: `irq_aggregator`

## Requirements
- R1: After `rst_n` is released, every mapped word reads zero, `irq_o` is low and `periph_rst_o` is low.
- R2: A high bit on `event_i` sets the matching latched-event bit at the next clock edge. The bit stays set after the pulse ends and reads back in bits 7:0 of byte address 0x20. The source positions are: 0 arbitration lost, 1 transmit error or transfer complete, 2 transmit buffer empty, 3 receive threshold reached, 4 bus idle, 5 selected as target, 6 deselected as target, 7 transmit buffer half empty.
- R3: A write to 0x20 clears each latched bit whose written bit is one. Bits written as zero keep their value.
- R4: If an event and a clear for the same bit arrive in the same cycle, the bit stays set.
- R5: The per-source mask at 0x28 stores bits 7:0 of the written word. Bits 31:8 read as zero.
- R6: The master switch at 0x1C is bit 31 only. Written bits 30:0 are ignored and read as zero.
- R7: `irq_o` is high one cycle after a cycle in which the master switch is set and at least one latched bit has its mask bit set. Otherwise `irq_o` is low.
- R8: Writing exactly 0x0000000A to 0x40 clears the latched bits, the mask and the master switch at the next edge. At that same edge `periph_rst_o` goes high, and it stays high for one cycle. The reset wins over an event that arrives in the same cycle.
- R9: Writing any other value to 0x40 changes nothing and produces no reset pulse. The word at 0x40 reads as zero.
- R10: Reads of unmapped addresses return zero, and writes to them change no mapped state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 8 | Byte address, used for both read and write |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| event_i | input | 8 | Event pulses from the sources, one bit per source |
| irq_o | output | 1 | Registered interrupt request, level high |
| periph_rst_o | output | 1 | One-cycle reset pulse to the rest of the controller |

## Verification
The interrupt path is driven with a set of distinct combinations: latched bits with no mask, a mask with the master switch off, the master switch on, and a clear while the output is high. These show the three gating terms apart and show the one-cycle output latency. Events are pulsed one source at a time and then several at once, which catches a wrong bit position or a bit that does not hold. Clears are written with mixed one/zero patterns and in the same cycle as an event, which separates write-one-to-clear from plain write and checks which side wins the collision. The reset trigger is written with near-miss values and then with the key, which separates a full-word compare from a partial one.

// File: rtl/irqa_pkg.sv
package irqa_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned N_SRC  = 8;

  localparam logic [ADDR_W-1:0] OFS_MASTER = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_LATCH  = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_KICK   = 8'h40;

  localparam logic [DATA_W-1:0] KICK_KEY   = 32'h0000_000A;
  localparam int unsigned MASTER_BIT = DATA_W - 1;

  typedef enum logic [2:0] {
    SRC_ARB_LOST  = 3'd0,
    SRC_TX_FAULT  = 3'd1,
    SRC_TX_EMPTY  = 3'd2,
    SRC_RX_LEVEL  = 3'd3,
    SRC_BUS_IDLE  = 3'd4,
    SRC_SELECTED  = 3'd5,
    SRC_RELEASED  = 3'd6,
    SRC_TX_HALF   = 3'd7
  } irq_src_e;

  // next value of one latched bit: a kick clears, an event beats a clear
  function automatic logic latch_next(input logic cur, input logic ev,
                                      input logic clr, input logic kick);
    if (kick)     return 1'b0;
    else if (ev)  return 1'b1;
    else if (clr) return 1'b0;
    else          return cur;
  endfunction

  function automatic logic want_irq(input logic [N_SRC-1:0] latched,
                                    input logic [N_SRC-1:0] mask,
                                    input logic master);
    return master & (|(latched & mask));
  endfunction
endpackage

// File: rtl/irqa_decode.sv
module irqa_decode
  import irqa_pkg::*;
(
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              wr_master,
  output logic              wr_mask,
  output logic [N_SRC-1:0]  clr_mask,
  output logic              kick_fire
);
  always_comb begin
    wr_master = wr_en && (addr == OFS_MASTER);
    wr_mask   = wr_en && (addr == OFS_MASK);
    clr_mask  = (wr_en && (addr == OFS_LATCH)) ? wdata[N_SRC-1:0] : '0;
    kick_fire = wr_en && (addr == OFS_KICK) && (wdata == KICK_KEY);
  end
endmodule

// File: rtl/irqa_latch_bank.sv
module irqa_latch_bank
  import irqa_pkg::*;
#(
  parameter int unsigned WIDTH = N_SRC
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] ev,
  input  logic [WIDTH-1:0] clr,
  input  logic             kick,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= latch_next(q[i], ev[i], clr[i], kick);
    end
  end
endmodule

// File: rtl/irqa_out_stage.sv
module irqa_out_stage
  import irqa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] latched,
  input  logic [N_SRC-1:0] mask,
  input  logic             master,
  input  logic             kick,
  output logic             irq_o,
  output logic             rst_pulse_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_o       <= 1'b0;
      rst_pulse_o <= 1'b0;
    end else begin
      irq_o       <= want_irq(latched, mask, master);
      rst_pulse_o <= kick;
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqa_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [N_SRC-1:0]  event_i,
  output logic              irq_o,
  output logic              periph_rst_o
);
  logic             wr_master;
  logic             wr_mask;
  logic [N_SRC-1:0] clr_mask;
  logic             kick_fire;
  logic [N_SRC-1:0] latch_q;
  logic [N_SRC-1:0] mask_q;
  logic             master_q;

  irqa_decode u_decode (
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .wr_master (wr_master),
    .wr_mask   (wr_mask),
    .clr_mask  (clr_mask),
    .kick_fire (kick_fire)
  );

  irqa_latch_bank #(.WIDTH(N_SRC)) u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .ev    (event_i),
    .clr   (clr_mask),
    .kick  (kick_fire),
    .q     (latch_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      master_q <= 1'b0;
    end else if (kick_fire) begin
      mask_q   <= '0;
      master_q <= 1'b0;
    end else begin
      if (wr_mask)   mask_q   <= wdata[N_SRC-1:0];
      if (wr_master) master_q <= wdata[MASTER_BIT];
    end
  end

  irqa_out_stage u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .latched     (latch_q),
    .mask        (mask_q),
    .master      (master_q),
    .kick        (kick_fire),
    .irq_o       (irq_o),
    .rst_pulse_o (periph_rst_o)
  );

  always_comb begin
    rdata = '0;
    case (addr)
      OFS_MASTER: rdata[MASTER_BIT]  = master_q;
      OFS_LATCH:  rdata[N_SRC-1:0]   = latch_q;
      OFS_MASK:   rdata[N_SRC-1:0]   = mask_q;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_aggregator_checker.sv
module irq_aggregator_checker
  import irqa_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [N_SRC-1:0]  event_i,
  input logic              irq_o,
  input logic              periph_rst_o,
  input logic [N_SRC-1:0]  latch_q,
  input logic [N_SRC-1:0]  mask_q,
  input logic              master_q,
  input logic [N_SRC-1:0]  clr_mask,
  input logic              kick_fire
);
  assert_event_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !kick_fire |=> ((latch_q & $past(event_i)) == $past(event_i)));

  assert_fall_needs_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !kick_fire |=> ((($past(latch_q) & ~latch_q) & ~$past(clr_mask)) == '0));

  assert_event_beats_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!kick_fire && ((event_i & clr_mask) != '0)) |=>
      ((latch_q & $past(event_i & clr_mask)) == $past(event_i & clr_mask)));

  assert_irq_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_o == $past(master_q && ((latch_q & mask_q) != '0))));

  assert_kick_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    kick_fire |=> (periph_rst_o && latch_q == '0 && mask_q == '0 && !master_q));

  assert_pulse_needs_key_R9: assert property (@(posedge clk) disable iff (!rst_n)
    periph_rst_o |-> $past(wr_en && addr == OFS_KICK && wdata == KICK_KEY));
endmodule

bind irq_aggregator irq_aggregator_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .addr         (addr),
  .wdata        (wdata),
  .event_i      (event_i),
  .irq_o        (irq_o),
  .periph_rst_o (periph_rst_o),
  .latch_q      (latch_q),
  .mask_q       (mask_q),
  .master_q     (master_q),
  .clr_mask     (clr_mask),
  .kick_fire    (kick_fire)
);

// File: tb/irq_aggregator_test.sv
`timescale 1ns/1ps
module irq_aggregator_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = 32'h0;
  logic [31:0] rdata;
  logic [7:0]  event_i = 8'h00;
  logic        irq_o;
  logic        periph_rst_o;

  int checks = 0;
  int fails  = 0;

  localparam logic [7:0] A_MASTER = 8'h1C;
  localparam logic [7:0] A_LATCH  = 8'h20;
  localparam logic [7:0] A_MASK   = 8'h28;
  localparam logic [7:0] A_KICK   = 8'h40;

  always #2.5 clk = ~clk;

  irq_aggregator uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .event_i(event_i), .irq_o(irq_o), .periph_rst_o(periph_rst_o)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive one write for one edge; returns at the following negedge
  task automatic wr(input logic [7:0] a, input logic [31:0] d,
                    input logic [7:0] ev = 8'h00);
    wr_en = 1'b1; addr = a; wdata = d; event_i = ev;
    @(negedge clk);
    wr_en = 1'b0; wdata = 32'h0; event_i = 8'h00;
  endtask

  task automatic pulse(input logic [7:0] ev);
    event_i = ev;
    @(negedge clk);
    event_i = 8'h00;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a;
    #0.5;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(A_MASTER, d); check("R1", "master", d, 32'h0);
    rd(A_LATCH, d);  check("R1", "latched", d, 32'h0);
    rd(A_MASK, d);   check("R1", "mask", d, 32'h0);
    check("R1", "irq", {31'h0, irq_o}, 32'h0);
    check("R1", "rst pulse", {31'h0, periph_rst_o}, 32'h0);
  endtask

  task automatic t_events;
    logic [31:0] d;
    logic [7:0] acc = 8'h00;
    for (int i = 0; i < 8; i++) begin
      pulse(8'h01 << i);
      acc |= 8'h01 << i;
      rd(A_LATCH, d);
      check("R2", $sformatf("walk source %0d", i), d, {24'h0, acc});
    end
    wr(A_LATCH, 32'hFF);
    pulse(8'h5A);
    @(negedge clk);
    rd(A_LATCH, d); check("R2", "group held", d, 32'h5A);
    wr(A_LATCH, 32'hFF);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    pulse(8'hFF);
    wr(A_LATCH, 32'hFFFF_FF0F);
    rd(A_LATCH, d); check("R3", "clear low nibble", d, 32'hF0);
    wr(A_LATCH, 32'h0);
    rd(A_LATCH, d); check("R3", "zero write keeps", d, 32'hF0);
    wr(A_LATCH, 32'h90);
    rd(A_LATCH, d); check("R3", "mixed clear", d, 32'h60);
    wr(A_LATCH, 32'hFF);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    pulse(8'h0C);
    wr(A_LATCH, 32'h0C, 8'h04);
    rd(A_LATCH, d); check("R4", "event beats clear", d, 32'h04);
    wr(A_LATCH, 32'hFF);
  endtask

  task automatic t_mask;
    logic [31:0] d;
    wr(A_MASK, 32'hFFFF_FFA5);
    rd(A_MASK, d); check("R5", "mask store", d, 32'hA5);
    wr(A_MASK, 32'h0);
    rd(A_MASK, d); check("R5", "mask zero", d, 32'h0);
  endtask

  task automatic t_master;
    logic [31:0] d;
    wr(A_MASTER, 32'h7FFF_FFFF);
    rd(A_MASTER, d); check("R6", "low bits ignored", d, 32'h0);
    wr(A_MASTER, 32'h8000_0000);
    rd(A_MASTER, d); check("R6", "bit31 set", d, 32'h8000_0000);
    wr(A_MASTER, 32'h0);
  endtask

  task automatic t_irq;
    pulse(8'h10);
    @(negedge clk);
    check("R7", "latched, no mask", {31'h0, irq_o}, 32'h0);
    wr(A_MASK, 32'h10);
    @(negedge clk);
    check("R7", "masked in, master off", {31'h0, irq_o}, 32'h0);
    wr(A_MASTER, 32'h8000_0000);
    check("R7", "latency one cycle", {31'h0, irq_o}, 32'h0);
    @(negedge clk);
    check("R7", "all terms on", {31'h0, irq_o}, 32'h1);
    wr(A_MASK, 32'hEF);
    @(negedge clk);
    check("R7", "other mask bits", {31'h0, irq_o}, 32'h0);
    wr(A_MASK, 32'h10);
    @(negedge clk);
    check("R7", "back on", {31'h0, irq_o}, 32'h1);
    wr(A_LATCH, 32'h10);
    @(negedge clk);
    check("R7", "clear drops irq", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_kick_miss;
    logic [31:0] d;
    pulse(8'h21);
    wr(A_MASK, 32'h33);
    wr(A_KICK, 32'h5);
    check("R9", "no pulse 0x5", {31'h0, periph_rst_o}, 32'h0);
    wr(A_KICK, 32'hB);
    wr(A_KICK, 32'h1A);
    check("R9", "no pulse 0x1A", {31'h0, periph_rst_o}, 32'h0);
    rd(A_LATCH, d); check("R9", "latched kept", d, 32'h21);
    rd(A_MASK, d);  check("R9", "mask kept", d, 32'h33);
    rd(A_KICK, d);  check("R9", "kick reads zero", d, 32'h0);
  endtask

  task automatic t_kick;
    logic [31:0] d;
    wr(A_MASTER, 32'h8000_0000);
    @(negedge clk);
    check("R8", "irq before kick", {31'h0, irq_o}, 32'h1);
    wr(A_KICK, 32'hA, 8'h40);
    check("R8", "pulse high", {31'h0, periph_rst_o}, 32'h1);
    rd(A_LATCH, d);  check("R8", "latched cleared", d, 32'h0);
    rd(A_MASK, d);   check("R8", "mask cleared", d, 32'h0);
    rd(A_MASTER, d); check("R8", "master cleared", d, 32'h0);
    @(negedge clk);
    check("R8", "pulse one cycle", {31'h0, periph_rst_o}, 32'h0);
    check("R8", "irq low after", {31'h0, irq_o}, 32'h0);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    pulse(8'h03);
    wr(8'h24, 32'hFFFF_FFFF);
    wr(8'h2C, 32'hFFFF_FFFF);
    rd(8'h24, d);   check("R10", "unmapped read", d, 32'h0);
    rd(A_LATCH, d); check("R10", "latched untouched", d, 32'h03);
    rd(A_MASK, d);  check("R10", "mask untouched", d, 32'h0);
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_events;
    t_clear;
    t_collision;
    t_mask;
    t_master;
    t_irq;
    t_kick_miss;
    t_kick;
    t_unmapped;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule